// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block holds two 32-bit registers that together decide whether a single interrupt request line is raised: an event register that records which sources have fired, and a mask register that says which sources may interrupt. Neither register is written directly. Each has one address where every 1 in the write data sets the matching bit, and a second address where every 1 clears it. Software can therefore change a single bit without a read-modify-write, and both addresses of a pair read back the same contents.

Hardware sources raise event bits through a pulse vector. Bit 31 of the mask is a global gate rather than a per-source enable. A dedicated hardware input can force this gate low, for example when a fatal condition is detected. The request line is registered: it follows the gated AND-OR of event and mask one clock later.

The register bus is plain and has no back-pressure. A write strobe is accepted in the cycle it is presented, and read data is a combinational function of the address. No valid/ready stream is involved, so every pin is a plain control or status pin.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A write to address 0x88 sets every writable mask bit that is 1 in the write data. Mask bits written as 0 keep their value.
- R2: A write to address 0x8C clears every mask bit that is 1 in the write data. Mask bits written as 0 keep their value.
- R3: Reads at 0x88 and 0x8C both return the current mask. Reads at 0x80 and 0x84 both return the current event register. Any other address reads as 0.
- R4: Bit 28 and bits 14 down to 10 of both registers, and bit 31 of the event register, always read as 0. Writes and hardware pulses do not change them.
- R5: After an active-low reset, both registers and the interrupt output are 0.
- R6: Mask bit 31 is a master gate. While it is 0, the interrupt output is 0 one cycle later, whatever the other bits hold.
- R7: The interrupt output equals mask[31] AND the OR over bits 0 to 30 of (event AND mask), as held in the registers one cycle earlier.
- R8: A 1 on hw_event[n] sets event bit n in the next cycle. When a software clear of the same bit arrives in the same cycle, the hardware set wins.
- R9: A write to address 0x80 sets, and a write to address 0x84 clears, every writable event bit that is 1 in the write data. Event bits written as 0 keep their value.
- R10: A 1 on hw_gate_drop clears mask bit 31 in the next cycle. It wins over a software set of bit 31 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data, 1 bits select the bits to set or clear |
| bus_rdata | output | 32 | Read data for bus_addr |
| hw_event | input | 31 | Hardware event pulses for event bits 0 to 30 |
| hw_gate_drop | input | 1 | Hardware request to clear the master gate |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check the following on every cycle: reserved bits stay at zero, the gate blocks the request line, the request line follows the registered AND-OR, a hardware event pulse lands, the gate drop wins, and set or clear writes reach the mask. Read-back aliasing across the four addresses and the zero read of unmapped addresses are combinational views of the bus. Only the bench's scenarios show these, comparing against a reference model under random mixed traffic. The same holds for the exact outcome of a software clear racing a hardware set, and for the reset state.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned GATE_BIT   = REG_W - 1;
  localparam int unsigned SRC_W      = REG_W - 1;

  // bits that never hold state: 28 and 14..10
  localparam logic [REG_W-1:0] RSVD_BITS  = 32'h1000_7C00;
  localparam logic [REG_W-1:0] MASK_LIVE  = ~RSVD_BITS;
  localparam logic [REG_W-1:0] EVENT_LIVE = ~RSVD_BITS & ~(32'h1 << GATE_BIT);

  localparam logic [ADDR_W-1:0] A_EV_SET = 8'h80;
  localparam logic [ADDR_W-1:0] A_EV_CLR = 8'h84;
  localparam logic [ADDR_W-1:0] A_MK_SET = 8'h88;
  localparam logic [ADDR_W-1:0] A_MK_CLR = 8'h8C;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_EVENT = 2'd1,
    RD_MASK  = 2'd2
  } rd_sel_t;

  typedef struct packed {
    logic ev_set;
    logic ev_clr;
    logic mk_set;
    logic mk_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_mask_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output wr_strobe_t        strb,
  output rd_sel_t           rd_sel
);
  always_comb begin
    strb.ev_set = wr && (addr == A_EV_SET);
    strb.ev_clr = wr && (addr == A_EV_CLR);
    strb.mk_set = wr && (addr == A_MK_SET);
    strb.mk_clr = wr && (addr == A_MK_CLR);
  end

  always_comb begin
    unique case (addr)
      A_EV_SET, A_EV_CLR: rd_sel = RD_EVENT;
      A_MK_SET, A_MK_CLR: rd_sel = RD_MASK;
      default:            rd_sel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/irq_setclr_reg.sv
// Per-bit register with priority: hw clear > hw set > sw clear > sw set > hold.
module irq_setclr_reg #(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    d = d | sw_set;
    d = d & ~sw_clr;
    d = d | hw_set;
    d = d & ~hw_clr;
    d = d & LIVE;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= d[i];
      end
    end else begin : g_tied
      assign q[i] = d[i];
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] mask,
  output logic         irq
);
  localparam int unsigned SRC = W - 1;
  logic any_src;

  always_comb any_src = |(ev[SRC-1:0] & mask[SRC-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= mask[W-1] & any_src;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [30:0]       hw_event,
  input  logic              hw_gate_drop,
  output logic              irq
);
  wr_strobe_t       strb;
  rd_sel_t          rd_sel;
  logic [REG_W-1:0] event_q, mask_q;
  logic [REG_W-1:0] ev_set, ev_clr, mk_set, mk_clr;
  logic [REG_W-1:0] ev_hw_set, mk_hw_clr;

  irq_addr_decode u_dec (
    .addr(bus_addr), .wr(bus_wr), .strb(strb), .rd_sel(rd_sel)
  );

  always_comb begin
    ev_set    = strb.ev_set ? bus_wdata : '0;
    ev_clr    = strb.ev_clr ? bus_wdata : '0;
    mk_set    = strb.mk_set ? bus_wdata : '0;
    mk_clr    = strb.mk_clr ? bus_wdata : '0;
    ev_hw_set = {1'b0, hw_event};
    mk_hw_clr = {hw_gate_drop, {SRC_W{1'b0}}};
  end

  irq_setclr_reg #(.W(REG_W), .LIVE(EVENT_LIVE)) u_event (
    .clk(clk), .rst_n(rst_n),
    .sw_set(ev_set), .sw_clr(ev_clr),
    .hw_set(ev_hw_set), .hw_clr('0),
    .q(event_q)
  );

  irq_setclr_reg #(.W(REG_W), .LIVE(MASK_LIVE)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .sw_set(mk_set), .sw_clr(mk_clr),
    .hw_set('0), .hw_clr(mk_hw_clr),
    .q(mask_q)
  );

  irq_combine #(.W(REG_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .ev(event_q), .mask(mask_q), .irq(irq)
  );

  always_comb begin
    unique case (rd_sel)
      RD_EVENT: bus_rdata = event_q;
      RD_MASK:  bus_rdata = mask_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk
  import irq_mask_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [30:0]       hw_event,
  input logic              hw_gate_drop,
  input logic [REG_W-1:0]  event_q,
  input logic [REG_W-1:0]  mask_q,
  input logic              irq
);
  localparam logic [REG_W-1:0] SRC_LIVE = MASK_LIVE & ~(32'h1 << GATE_BIT);

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & RSVD_BITS) == '0) && ((event_q & ~EVENT_LIVE) == '0));

  assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[GATE_BIT] |=> !irq);

  assert_irq_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[GATE_BIT] && |(event_q[SRC_W-1:0] & mask_q[SRC_W-1:0])) |=> irq);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(event_q[SRC_W-1:0] & mask_q[SRC_W-1:0])) |=> !irq);

  assert_hw_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_event) |=> ((event_q[SRC_W-1:0] & $past(hw_event) & EVENT_LIVE[SRC_W-1:0])
                     == ($past(hw_event) & EVENT_LIVE[SRC_W-1:0])));

  assert_gate_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_gate_drop |=> !mask_q[GATE_BIT]);

  assert_mask_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MK_SET) |=>
      ((mask_q & $past(bus_wdata) & SRC_LIVE) == ($past(bus_wdata) & SRC_LIVE)));

  assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MK_CLR) |=> ((mask_q & $past(bus_wdata)) == '0));
endmodule

bind irq_mask_ctrl irq_mask_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .hw_event(hw_event), .hw_gate_drop(hw_gate_drop),
  .event_q(event_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RSVD = 32'h1000_7C00;
  localparam logic [31:0] MK_W = ~RSVD;
  localparam logic [31:0] EV_W = ~RSVD & 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [30:0] hw_event = '0;
  logic        hw_gate_drop = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] m_mask = '0, m_ev = '0;
  logic        m_irq = 1'b0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_mask(logic [31:0] cur, logic wr, logic [7:0] a,
                                           logic [31:0] d, logic drop);
    logic [31:0] r = cur;
    if (wr && a == 8'h88) r = r | (d & MK_W);
    if (wr && a == 8'h8C) r = r & ~d;
    if (drop) r[31] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] nxt_ev(logic [31:0] cur, logic wr, logic [7:0] a,
                                         logic [31:0] d, logic [30:0] hw);
    logic [31:0] r = cur;
    if (wr && a == 8'h80) r = r | (d & EV_W);
    if (wr && a == 8'h84) r = r & ~d;
    r = r | ({1'b0, hw} & EV_W);
    return r;
  endfunction

  function automatic logic irq_of(logic [31:0] mk, logic [31:0] ev);
    return mk[31] & (|(mk[30:0] & ev[30:0]));
  endfunction

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(logic wr, logic [7:0] a, logic [31:0] d, logic [30:0] hw, logic drop);
    bus_wr = wr; bus_addr = a; bus_wdata = d; hw_event = hw; hw_gate_drop = drop;
    @(posedge clk);
    m_irq  = irq_of(m_mask, m_ev);
    m_mask = nxt_mask(m_mask, wr, a, d, drop);
    m_ev   = nxt_ev(m_ev, wr, a, d, hw);
    @(negedge clk);
    bus_wr = 1'b0; hw_event = '0; hw_gate_drop = 1'b0;
    chk("R7 irq", {31'b0, irq}, {31'b0, m_irq});
    bus_addr = 8'h88; #1 chk("R1/R2 mask read at 88", bus_rdata, m_mask);
    bus_addr = 8'h8C; #1 chk("R3 mask read at 8C", bus_rdata, m_mask);
    bus_addr = 8'h80; #1 chk("R9 event read at 80", bus_rdata, m_ev);
    bus_addr = 8'h84; #1 chk("R3 event read at 84", bus_rdata, m_ev);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: reset state
    bus_addr = 8'h88; #1 chk("R5 mask after reset", bus_rdata, 32'h0);
    bus_addr = 8'h80; #1 chk("R5 event after reset", bus_rdata, 32'h0);
    chk("R5 irq after reset", {31'b0, irq}, 32'h0);
    @(negedge clk);

    // R4: reserved bits ignore writes and hardware pulses
    step(1'b1, 8'h88, 32'hFFFF_FFFF, '0, 1'b0);
    chk("R4 mask reserved zero", m_mask & RSVD, 32'h0);
    step(1'b1, 8'h80, 32'hFFFF_FFFF, 31'h7FFF_FFFF, 1'b0);
    bus_addr = 8'h80; #1 chk("R4 event reserved read", bus_rdata & (RSVD | 32'h8000_0000), 32'h0);
    // R7: irq raised one cycle after
    step(1'b0, 8'h00, '0, '0, 1'b0);
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    // R3: unmapped address reads zero
    bus_addr = 8'h90; #1 chk("R3 unmapped read", bus_rdata, 32'h0);
    bus_addr = 8'h00; #1 chk("R3 unmapped read 00", bus_rdata, 32'h0);
    // R10: hardware drop wins over software set of the gate
    step(1'b1, 8'h88, 32'h8000_0000, '0, 1'b1);
    bus_addr = 8'h88; #1 chk("R10 gate cleared", {31'b0, bus_rdata[31]}, 32'h0);
    // R6: gate low blocks irq even with all sources pending
    step(1'b0, 8'h00, '0, '0, 1'b0);
    chk("R6 gate blocks irq", {31'b0, irq}, 32'h0);
    // R2: clear address with zeros leaves mask untouched
    step(1'b1, 8'h8C, 32'h0, '0, 1'b0);
    // R8: hardware set wins over software clear
    step(1'b1, 8'h84, 32'h0000_0005, 31'h0000_0001, 1'b0);
    bus_addr = 8'h80; #1 chk("R8 set wins", bus_rdata[2:0], 3'b011 & m_ev[2:0]);
    chk("R8 set wins bit0", {31'b0, m_ev[0]}, 32'h1);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [30:0] hw;
      case ($urandom % 6)
        0: a = 8'h80; 1: a = 8'h84; 2: a = 8'h88; 3: a = 8'h8C;
        4: a = 8'h88; default: a = 8'h44;
      endcase
      d  = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
      hw = ($urandom % 4 == 0) ? 31'($urandom) & (31'h1 << ($urandom % 31)) : '0;
      step(($urandom % 4) != 0, a, d, hw, ($urandom % 16) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule